// File: doc/BRIEF.md
# Two-Digit Multiplexed Decimal Display Driver

The block takes a 4-bit unsigned value and shows it in decimal, 00 to 15, on a pair of seven-segment displays. The two displays share one set of segment lines, and a single digit-select line chooses which one is lit. Inside, the value is split into a tens digit and a ones digit. A refresh timer produces a square wave that acts as the multiplexer select for the segment decoder and also drives the digit-select output.

The half-period of the refresh wave is a parameter. The default is 400,000 clock cycles, which gives 8 ms high and 8 ms low on a 50 MHz clock. A simulation can set it to 400 cycles, which gives an 8 µs half-period at the same clock rate. The reset is synchronous and active-low.

Top module: `dual_digit_dec_display`

## Requirements
- R1: While `rst_n` is low at a clock edge, `digit_sel` becomes 0 and the refresh timer restarts. During reset, the segments show the ones digit of `value`.
- R2: When `digit_sel` is 1, the segments show the tens digit. The tens digit is 1 for values 10 to 15 and 0 for values 0 to 9.
- R3: When `digit_sel` is 0, the segments show the ones digit. The ones digit is `value` for values 0 to 9 and `value` minus 10 for values 10 to 15.
- R4: After reset is released, `digit_sel` stays 0 for exactly `HALF_CYCLES` rising edges. From then on it inverts every `HALF_CYCLES` edges.
- R5: `seg_n` is active-low, with bit order {g,f,e,d,c,b,a}. The active-high patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F in hex.
- R6: A change on `value` reaches `seg_n` in the same cycle, with no register in the path.
- R7: `seg_n` switches to the other digit in the same cycle that `digit_sel` toggles. No blank interval is inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| value | input | 4 | Unsigned value to display |
| seg_n | output | 7 | Segment lines, active low, {g,f,e,d,c,b,a} |
| digit_sel | output | 1 | Digit select: 0 selects the ones display, 1 selects the tens display |

## Verification
The hardest situation to reach from the ports is a change on `value` in the middle of a refresh half, and most of all in the tens half. Nothing in a plain sweep puts the inputs there. The stimulus keeps its own count of edges since reset, so it can place value changes at chosen points. Each value is first applied on the first cycle of a ones half. One extra value change is then made halfway through a tens half. The cycles on either side of each toggle are checked, so the digit swap is seen at the exact edge where it happens.

// File: rtl/ddd_pkg.sv
// Package: shared types for the two-digit decimal display driver.
// Assumes a 4-bit digit code and a 7-line segment bus ordered {g,f,e,d,c,b,a}.
package ddd_pkg;
    typedef logic [3:0] digit_t;
    typedef logic [6:0] seg_t;

    localparam digit_t DIGIT_RADIX = 4'd10;
    localparam seg_t   SEG_ALL_OFF = 7'h7F;
endpackage

// File: rtl/ddd_bin_split.sv
// Module: splits a 4-bit binary value into tens and ones decimal digits.
// Built from a comparator, a subtractor and a 2-to-1 selector.
// Assumes the input is at most 15, so the tens digit is 0 or 1.
module ddd_bin_split
    import ddd_pkg::*;
(
    input  digit_t bin_in,
    output digit_t tens,
    output digit_t ones
);
    logic   at_least_ten;
    digit_t minus_ten;

    // Comparator and subtractor that feed the ones selector.
    always_comb begin
        at_least_ten = (bin_in >= DIGIT_RADIX);
        minus_ten    = bin_in - DIGIT_RADIX;
    end

    // Pick the ones digit and form the tens digit from the compare result.
    always_comb begin
        ones = at_least_ten ? minus_ten : bin_in;
        tens = {3'b000, at_least_ten};
    end
endmodule

// File: rtl/ddd_refresh_timer.sv
// Module: square-wave refresh timer. refresh inverts every HALF_CYCLES edges.
// Assumes HALF_CYCLES >= 1. A synchronous active-low reset clears the counter
// and drives refresh to 0.
module ddd_refresh_timer #(
    parameter int HALF_CYCLES = 400000
) (
    input  logic clk,
    input  logic rst_n,
    output logic refresh
);
    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    // Flag the final cycle of each half-period.
    always_comb wrap = (cnt == LAST);

    // Count cycles within a half-period and invert refresh on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            refresh <= 1'b0;
        end else if (wrap) begin
            cnt     <= '0;
            refresh <= ~refresh;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ddd_seg_decode.sv
// Module: maps a decimal digit code to active-low segment lines {g,f,e,d,c,b,a}.
// Purely combinational. Codes 10 to 15 turn every segment off.
module ddd_seg_decode
    import ddd_pkg::*;
(
    input  digit_t digit,
    output seg_t   seg_n
);
    seg_t lit;

    // Active-high pattern lookup for one digit.
    always_comb begin
        case (digit)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
    end

    // Invert for the active-low segment drivers.
    always_comb seg_n = ~lit;
endmodule

// File: rtl/dual_digit_dec_display.sv
// Module: top of the two-digit multiplexed decimal display driver.
// The refresh wave drives both the digit mux select and digit_sel.
// Assumes rst_n is synchronous to clk and value is synchronous to clk.
module dual_digit_dec_display
    import ddd_pkg::*;
#(
    parameter int HALF_CYCLES = 400000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] value,
    output logic [6:0] seg_n,
    output logic       digit_sel
);
    digit_t tens_d;
    digit_t ones_d;
    digit_t shown;
    logic   refresh;

    ddd_bin_split u_split (
        .bin_in (value),
        .tens   (tens_d),
        .ones   (ones_d)
    );

    ddd_refresh_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .refresh (refresh)
    );

    // Digit selector: refresh high shows tens, low shows ones.
    always_comb shown = refresh ? tens_d : ones_d;

    ddd_seg_decode u_dec (
        .digit (shown),
        .seg_n (seg_n)
    );

    // The refresh wave is also the physical digit-select line.
    always_comb digit_sel = refresh;
endmodule

// File: rtl/ddd_display_checker.sv
// Module: assertion checker for dual_digit_dec_display, attached by bind.
// Watches only the ports and keeps its own count of how long the select is held.
module ddd_display_checker #(
    parameter int HALF_CYCLES = 400000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] value,
    input logic [6:0] seg_n,
    input logic       digit_sel
);
    logic        prev_sel;
    logic [31:0] hold_cnt;

    // Track the previous select and the number of cycles it has been held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel <= 1'b0;
            hold_cnt <= '0;
        end else begin
            prev_sel <= digit_sel;
            if (digit_sel != prev_sel) hold_cnt <= '0;
            else if (hold_cnt != 32'hFFFF_FFFF) hold_cnt <= hold_cnt + 1;
        end
    end

    // R4: the select is never held longer than one half-period.
    p_hold_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= 32'(HALF_CYCLES));

    // R4: the select never toggles before a full half-period has passed.
    p_toggle_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_sel != prev_sel) |-> (hold_cnt >= 32'(HALF_CYCLES - 1)));

    // R2: in the tens half, values 0 to 9 show the pattern for digit 0.
    p_tens_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_sel && value < 4'd10) |-> (seg_n == ~7'h3F));

    // R2: in the tens half, values 10 to 15 show the pattern for digit 1.
    p_tens_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_sel && value >= 4'd10) |-> (seg_n == ~7'h06));

    // R3: in the ones half, the display is never blank.
    p_ones_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !digit_sel |-> (seg_n != 7'h7F));
endmodule

bind dual_digit_dec_display ddd_display_checker #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .value     (value),
    .seg_n     (seg_n),
    .digit_sel (digit_sel)
);

// File: tb/dual_digit_dec_display_bench.sv
// Bench: scoreboard for the two-digit decimal display driver. The driver
// pushes expected items, tagged with the edge count at which they hold, and
// the monitor pops them after each falling edge and compares.
module dual_digit_dec_display_bench;
    localparam int HALF = 400;

    typedef struct {
        int         cyc;
        logic [6:0] seg;
        logic       sel;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] value = 4'd0;
    logic [6:0] seg_n;
    logic       digit_sel;

    item_t q[$];
    int    n_edges = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    dual_digit_dec_display #(.HALF_CYCLES(HALF)) u_dual_digit_dec_display (
        .clk       (clk),
        .rst_n     (rst_n),
        .value     (value),
        .seg_n     (seg_n),
        .digit_sel (digit_sel)
    );

    always #4 clk = ~clk;

    // Expected active-low pattern for one digit (R5 table).
    function automatic logic [6:0] exp_seg(input int d);
        logic [6:0] p;
        case (d)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F;
            4: p = 7'h66; 5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07;
            8: p = 7'h7F; 9: p = 7'h6F; default: p = 7'h00;
        endcase
        return ~p;
    endfunction

    // Push one expected item: for value v, the digit selected by sel.
    task automatic push(input int cyc, input int v, input logic sel, input string req);
        item_t it;
        it.cyc = cyc;
        it.sel = sel;
        it.seg = sel ? exp_seg(v / 10) : exp_seg(v % 10);
        it.req = req;
        q.push_back(it);
    endtask

    // Wait on falling edges until the edge count reaches the target.
    task automatic wait_cyc(input int target);
        while (n_edges < target) @(negedge clk);
    endtask

    // Count rising edges taken with reset released.
    always @(posedge clk) if (rst_n) n_edges <= n_edges + 1;

    // Monitor: after each falling edge, compare the items that are due.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].cyc <= n_edges) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (seg_n !== it.seg || digit_sel !== it.sel) begin
                    fails++;
                    $display("FAIL %s at edge %0d: seg_n=%h sel=%b expected seg_n=%h sel=%b",
                             it.req, it.cyc, seg_n, digit_sel, it.seg, it.sel);
                end
            end
        end
    end

    // Driver: reset, sweep all values, then a change in the middle of a half.
    initial begin
        int base;
        value = 4'd15;
        repeat (3) @(negedge clk);
        push(0, 15, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        for (int v = 0; v < 16; v++) begin
            base = v * 2 * HALF;
            wait_cyc(base);
            value = 4'(v);
            push(base,            v, 1'b0, (v >= 10) ? "R3" : "R6");
            push(base + HALF - 1, v, 1'b0, "R4");
            push(base + HALF,     v, 1'b1, "R7");
            push(base + 2*HALF - 1, v, 1'b1, "R2");
        end
        base = 16 * 2 * HALF;
        push(base, 15, 1'b0, "R4");
        wait_cyc(base + HALF + HALF/2);
        value = 4'd7;
        push(base + HALF + HALF/2, 7, 1'b1, "R6");
        wait_cyc(base + HALF + HALF/2 + 1);
        value = 4'd12;
        push(base + HALF + HALF/2 + 1, 12, 1'b1, "R6");
        push(base + 2*HALF, 12, 1'b0, "R7");
        wait_cyc(base + 2*HALF + 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        push(n_edges, 12, 1'b0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    // End of run: summary after the driver finishes, or after the watchdog expires.
    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 60000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual wd=%0d expected done", wd);
        end
        if (q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule